// File: doc/BRIEF.md
# Scatter-Gather Copy Engine

This block copies data between memory regions by walking a list of transfer descriptors. Software places the descriptors back to back in memory, presents the address of the first one together with a one-cycle start pulse, and the engine then fetches each descriptor in turn and copies the requested number of bytes from its source address to its destination address. Each descriptor occupies three 32-bit words: the source address, then the destination address, then a control word that holds the byte count in its low bits and a last-entry flag in bit 31.

Data moves in bursts. The engine reads one burst of words into a local buffer through the read port, then writes those words out through the write port, and repeats until the descriptor's count is exhausted. Only the descriptor marked last ends the list successfully. A malformed count, a read error or a write error ends the list early. Every outcome is recorded in a five-bit sticky status register that software clears by writing ones. The interrupt output is asserted whenever any status bit is set.

Both memory ports use a held-request handshake. The engine holds a request and its address (and write data) steady until the memory answers with a one-cycle response (`rd_valid_i` or `wr_ack_i`), optionally flagged as an error. At most one request is outstanding at a time.

Top module: `sg_dma_engine`

## Requirements
- R1: After reset, `busy_o`, `irq_o`, `rd_req_o` and `wr_req_o` are low and `status_o` is zero.
- R2: A descriptor at byte address p is read as three words: the source address at p, the destination address at p+4, and the control word at p+8. Control bits [17:0] are the byte count, bit 31 is the last flag, and bits [30:18] have no effect.
- R3: Data is copied one 32-bit word at a time, unchanged and in little-endian order. Source and destination addresses both advance by 4 per word, and all request addresses are word aligned. Each burst reads BURST_WORDS words before any of them is written.
- R4: When a descriptor without the last flag completes, the next descriptor is fetched at its address plus 12.
- R5: When the last-flagged descriptor completes, status bit 0 (read completed) and bit 1 (write completed) are set in the same cycle that `busy_o` falls. These bits are never set earlier.
- R6: A byte count that is zero, or that is not a multiple of the burst size (BURST_WORDS*4 bytes, 256 at default), sets status bit 4 and ends the list. No data of that descriptor is read or written.
- R7: A read response flagged with `rd_err_i`, whether during a descriptor fetch or a data read, sets status bit 2 and ends the list at once.
- R8: A write response flagged with `wr_err_i` sets status bit 3 and ends the list at once. Later words are not written.
- R9: A start pulse while idle latches `list_base_i` and raises `busy_o` on the next cycle. A start pulse while busy has no effect.
- R10: Status bits are sticky. Each bit clears only when the matching bit of `status_clr_i` is 1, and other bits keep their value.
- R11: `irq_o` is high exactly when at least one status bit is set.
- R12: The read and write requests are never high together, and neither is high while the engine is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle pulse that begins a list |
| list_base_i | input | ADDR_W | Byte address of the first descriptor |
| status_clr_i | input | 5 | Write-one-to-clear mask for the status bits |
| busy_o | output | 1 | Engine is processing a list |
| irq_o | output | 1 | Interrupt: OR of all status bits |
| status_o | output | 5 | Sticky status: 0 read done, 1 write done, 2 read error, 3 write error, 4 descriptor error |
| rd_req_o | output | 1 | Read request, held until answered |
| rd_addr_o | output | ADDR_W | Read byte address |
| rd_valid_i | input | 1 | Read response strobe |
| rd_data_i | input | 32 | Read response data |
| rd_err_i | input | 1 | Read response carries an error |
| wr_req_o | output | 1 | Write request, held until answered |
| wr_addr_o | output | ADDR_W | Write byte address |
| wr_data_o | output | 32 | Write data |
| wr_ack_i | input | 1 | Write response strobe |
| wr_err_i | input | 1 | Write response carries an error |

## Verification
The bench builds the engine with BURST_WORDS set to 4, so a burst is 16 bytes. Descriptors of 32 and 48 bytes therefore span several bursts while keeping the simulation short. The same setting makes misaligned counts such as 8 and 20 bytes cheap to express, so the alignment rule can be exercised alongside multi-descriptor lists. ADDR_W and CNT_W stay at their defaults, so the full 32-bit address words and the 18-bit count field with reserved bits set are covered.

// File: rtl/sg_dma_pkg.sv
package sg_dma_pkg;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_FETCH,
      ST_READ,
      ST_WRITE
   } sg_state_e;

   localparam int STAT_W      = 5;
   localparam int SB_RD_DONE  = 0;
   localparam int SB_WR_DONE  = 1;
   localparam int SB_RD_ERR   = 2;
   localparam int SB_WR_ERR   = 3;
   localparam int SB_DESC_ERR = 4;

   localparam int DATA_W      = 32;
   localparam int WORD_BYTES  = 4;
   localparam int DESC_WORDS  = 3;
   localparam int LAST_BIT    = 31;

endpackage

// File: rtl/sg_dma_burst_buf.sv
module sg_dma_burst_buf #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 64,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              we_i,
   input  logic [IDX_W-1:0]  widx_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [IDX_W-1:0]  ridx_i,
   output logic [DATA_W-1:0] rdata_o
);

   logic [DEPTH-1:0][DATA_W-1:0] words;

   for (genvar g = 0; g < DEPTH; g++) begin : g_word
      logic [DATA_W-1:0] word_q;
      always_ff @(posedge clk) begin
         if (we_i && (widx_i == IDX_W'(g))) begin
            word_q <= wdata_i;
         end
      end
      assign words[g] = word_q;
   end

   assign rdata_o = words[ridx_i];

endmodule

// File: rtl/sg_dma_status.sv
module sg_dma_status #(
   parameter int STAT_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [STAT_W-1:0] set_i,
   input  logic [STAT_W-1:0] clr_i,
   output logic [STAT_W-1:0] status_o
);

   for (genvar g = 0; g < STAT_W; g++) begin : g_bit
      logic bit_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            bit_q <= 1'b0;
         end else if (set_i[g]) begin
            bit_q <= 1'b1;
         end else if (clr_i[g]) begin
            bit_q <= 1'b0;
         end
      end
      assign status_o[g] = bit_q;
   end

endmodule

// File: rtl/sg_dma_ctrl.sv
module sg_dma_ctrl
   import sg_dma_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int CNT_W       = 18,
   parameter int BURST_WORDS = 64,
   localparam int IDX_W      = $clog2(BURST_WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [ADDR_W-1:0] base_i,
   output logic              busy_o,
   output logic              rd_req_o,
   output logic [ADDR_W-1:0] rd_addr_o,
   input  logic              rd_valid_i,
   input  logic [DATA_W-1:0] rd_data_i,
   input  logic              rd_err_i,
   output logic              wr_req_o,
   output logic [ADDR_W-1:0] wr_addr_o,
   output logic [DATA_W-1:0] wr_data_o,
   input  logic              wr_ack_i,
   input  logic              wr_err_i,
   output logic              buf_we_o,
   output logic [IDX_W-1:0]  buf_widx_o,
   output logic [DATA_W-1:0] buf_wdata_o,
   output logic [IDX_W-1:0]  buf_ridx_o,
   input  logic [DATA_W-1:0] buf_rdata_i,
   output logic [STAT_W-1:0] evt_o
);

   localparam int                ALIGN_W     = $clog2(BURST_WORDS * WORD_BYTES);
   localparam logic [CNT_W-1:0]  BURST_BYTES = CNT_W'(BURST_WORDS * WORD_BYTES);
   localparam logic [ADDR_W-1:0] STEP        = ADDR_W'(WORD_BYTES);
   localparam logic [ADDR_W-1:0] STRIDE      = ADDR_W'(DESC_WORDS * WORD_BYTES);
   localparam logic [IDX_W-1:0]  IDX_LAST    = IDX_W'(BURST_WORDS - 1);

   sg_state_e         state_q, state_n;
   logic [ADDR_W-1:0] desc_ptr_q, src_q, dst_q;
   logic [CNT_W-1:0]  remain_q;
   logic              last_q;
   logic [1:0]        fidx_q;
   logic [IDX_W-1:0]  widx_q;

   logic [CNT_W-1:0]  cnt_field;
   logic              cnt_bad;
   logic              widx_end;
   logic              desc_end;
   logic              rd_ok, wr_ok;

   assign cnt_field = rd_data_i[CNT_W-1:0];
   assign cnt_bad   = (cnt_field == '0) || (|cnt_field[ALIGN_W-1:0]);
   assign widx_end  = (widx_q == IDX_LAST);
   assign desc_end  = (remain_q == BURST_BYTES);
   assign rd_ok     = rd_valid_i && !rd_err_i;
   assign wr_ok     = wr_ack_i && !wr_err_i;

   // Port drive
   always_comb begin
      busy_o      = (state_q != ST_IDLE);
      rd_req_o    = (state_q == ST_FETCH) || (state_q == ST_READ);
      rd_addr_o   = (state_q == ST_FETCH) ? (desc_ptr_q + ADDR_W'({fidx_q, 2'b00})) : src_q;
      wr_req_o    = (state_q == ST_WRITE);
      wr_addr_o   = dst_q;
      wr_data_o   = buf_rdata_i;
      buf_we_o    = (state_q == ST_READ) && rd_ok;
      buf_widx_o  = widx_q;
      buf_wdata_o = rd_data_i;
      buf_ridx_o  = widx_q;
   end

   // Sequencing and status events
   always_comb begin
      state_n = state_q;
      evt_o   = '0;
      unique case (state_q)
         ST_IDLE: begin
            if (start_i) state_n = ST_FETCH;
         end
         ST_FETCH: begin
            if (rd_valid_i) begin
               if (rd_err_i) begin
                  evt_o[SB_RD_ERR] = 1'b1;
                  state_n          = ST_IDLE;
               end else if (fidx_q == 2'd2) begin
                  if (cnt_bad) begin
                     evt_o[SB_DESC_ERR] = 1'b1;
                     state_n            = ST_IDLE;
                  end else begin
                     state_n = ST_READ;
                  end
               end
            end
         end
         ST_READ: begin
            if (rd_valid_i) begin
               if (rd_err_i) begin
                  evt_o[SB_RD_ERR] = 1'b1;
                  state_n          = ST_IDLE;
               end else if (widx_end) begin
                  state_n = ST_WRITE;
               end
            end
         end
         ST_WRITE: begin
            if (wr_ack_i) begin
               if (wr_err_i) begin
                  evt_o[SB_WR_ERR] = 1'b1;
                  state_n          = ST_IDLE;
               end else if (widx_end) begin
                  if (!desc_end) begin
                     state_n = ST_READ;
                  end else if (last_q) begin
                     evt_o[SB_RD_DONE] = 1'b1;
                     evt_o[SB_WR_DONE] = 1'b1;
                     state_n           = ST_IDLE;
                  end else begin
                     state_n = ST_FETCH;
                  end
               end
            end
         end
         default: state_n = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
      end else begin
         state_q <= state_n;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         desc_ptr_q <= '0;
         src_q      <= '0;
         dst_q      <= '0;
         remain_q   <= '0;
         last_q     <= 1'b0;
         fidx_q     <= '0;
         widx_q     <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  desc_ptr_q <= base_i;
                  fidx_q     <= '0;
               end
            end
            ST_FETCH: begin
               if (rd_ok) begin
                  fidx_q <= fidx_q + 2'd1;
                  widx_q <= '0;
                  unique case (fidx_q)
                     2'd0:    src_q <= rd_data_i[ADDR_W-1:0];
                     2'd1:    dst_q <= rd_data_i[ADDR_W-1:0];
                     default: begin
                        remain_q <= cnt_field;
                        last_q   <= rd_data_i[LAST_BIT];
                     end
                  endcase
               end
            end
            ST_READ: begin
               if (rd_ok) begin
                  src_q  <= src_q + STEP;
                  widx_q <= widx_q + 1'b1;
               end
            end
            ST_WRITE: begin
               if (wr_ok) begin
                  dst_q  <= dst_q + STEP;
                  widx_q <= widx_q + 1'b1;
                  if (widx_end) begin
                     remain_q <= remain_q - BURST_BYTES;
                     if (desc_end) begin
                        desc_ptr_q <= desc_ptr_q + STRIDE;
                        fidx_q     <= '0;
                     end
                  end
               end
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/sg_dma_engine.sv
module sg_dma_engine
   import sg_dma_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int CNT_W       = 18,
   parameter int BURST_WORDS = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [ADDR_W-1:0] list_base_i,
   input  logic [4:0]        status_clr_i,
   output logic              busy_o,
   output logic              irq_o,
   output logic [4:0]        status_o,
   output logic              rd_req_o,
   output logic [ADDR_W-1:0] rd_addr_o,
   input  logic              rd_valid_i,
   input  logic [31:0]       rd_data_i,
   input  logic              rd_err_i,
   output logic              wr_req_o,
   output logic [ADDR_W-1:0] wr_addr_o,
   output logic [31:0]       wr_data_o,
   input  logic              wr_ack_i,
   input  logic              wr_err_i
);

   localparam int IDX_W   = $clog2(BURST_WORDS);
   localparam int ALIGN_W = $clog2(BURST_WORDS * WORD_BYTES);

   if (BURST_WORDS < 2 || (BURST_WORDS & (BURST_WORDS - 1)) != 0) begin : g_bad_burst
      $error("BURST_WORDS must be a power of two of at least 2");
   end
   if (ADDR_W < 8 || ADDR_W > DATA_W) begin : g_bad_addr
      $error("ADDR_W must lie between 8 and 32");
   end
   if (CNT_W <= ALIGN_W || CNT_W > LAST_BIT) begin : g_bad_cnt
      $error("CNT_W must exceed the burst alignment and stay below the last flag");
   end

   logic              buf_we;
   logic [IDX_W-1:0]  buf_widx, buf_ridx;
   logic [DATA_W-1:0] buf_wdata, buf_rdata;
   logic [STAT_W-1:0] evt;

   sg_dma_ctrl #(
      .ADDR_W      (ADDR_W),
      .CNT_W       (CNT_W),
      .BURST_WORDS (BURST_WORDS)
   ) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .base_i      (list_base_i),
      .busy_o      (busy_o),
      .rd_req_o    (rd_req_o),
      .rd_addr_o   (rd_addr_o),
      .rd_valid_i  (rd_valid_i),
      .rd_data_i   (rd_data_i),
      .rd_err_i    (rd_err_i),
      .wr_req_o    (wr_req_o),
      .wr_addr_o   (wr_addr_o),
      .wr_data_o   (wr_data_o),
      .wr_ack_i    (wr_ack_i),
      .wr_err_i    (wr_err_i),
      .buf_we_o    (buf_we),
      .buf_widx_o  (buf_widx),
      .buf_wdata_o (buf_wdata),
      .buf_ridx_o  (buf_ridx),
      .buf_rdata_i (buf_rdata),
      .evt_o       (evt)
   );

   sg_dma_burst_buf #(
      .DATA_W (DATA_W),
      .DEPTH  (BURST_WORDS)
   ) u_buf (
      .clk     (clk),
      .we_i    (buf_we),
      .widx_i  (buf_widx),
      .wdata_i (buf_wdata),
      .ridx_i  (buf_ridx),
      .rdata_o (buf_rdata)
   );

   sg_dma_status #(
      .STAT_W (STAT_W)
   ) u_status (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_i    (evt),
      .clr_i    (status_clr_i),
      .status_o (status_o)
   );

   assign irq_o = |status_o;

endmodule

// File: rtl/sg_dma_engine_chk.sv
module sg_dma_engine_chk #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy_o,
   input logic              irq_o,
   input logic [4:0]        status_o,
   input logic [4:0]        status_clr_i,
   input logic              rd_req_o,
   input logic [ADDR_W-1:0] rd_addr_o,
   input logic              rd_valid_i,
   input logic              rd_err_i,
   input logic              wr_req_o,
   input logic [ADDR_W-1:0] wr_addr_o,
   input logic              wr_ack_i,
   input logic              wr_err_i
);

   p_ports_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_req_o && wr_req_o));

   p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (!rd_req_o && !wr_req_o));

   p_word_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req_o |-> rd_addr_o[1:0] == 2'b00) and (wr_req_o |-> wr_addr_o[1:0] == 2'b00));

   p_done_at_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status_o[0]) |-> $fell(busy_o));

   p_rd_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req_o && rd_valid_i && rd_err_i) |=> (!busy_o && status_o[2]));

   p_wr_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req_o && wr_ack_i && wr_err_i) |=> (!busy_o && status_o[3]));

   p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ((status_o & $past(status_o & ~status_clr_i)) == $past(status_o & ~status_clr_i)));

   p_irq_fall_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_o) |-> $past(|status_clr_i));

endmodule

bind sg_dma_engine sg_dma_engine_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sg_dma_engine_bench.sv
`timescale 1ns/1ps
module sg_dma_engine_bench;

   localparam int BW = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [31:0] list_base_i = '0;
   logic [4:0]  status_clr_i = '0;
   logic        busy_o, irq_o;
   logic [4:0]  status_o;
   logic        rd_req_o, wr_req_o;
   logic [31:0] rd_addr_o, wr_addr_o, wr_data_o;
   logic        rd_valid_i = 1'b0, rd_err_i = 1'b0;
   logic [31:0] rd_data_i = '0;
   logic        wr_ack_i = 1'b0, wr_err_i = 1'b0;

   logic [31:0] mem [1024];
   logic        err_rd_en = 1'b0, err_wr_en = 1'b0;
   logic [31:0] err_rd_addr = '0, err_wr_addr = '0;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;

   // Table: control word per single-descriptor run, and the expected status
   localparam logic [31:0] T_CTRL [6] = '{32'h8000_0010, 32'h8000_0030, 32'h8000_0000,
                                          32'h8000_0014, 32'h8000_0008, 32'hFFFC_0020};
   localparam logic [4:0]  T_ST   [6] = '{5'h03, 5'h03, 5'h10, 5'h10, 5'h10, 5'h03};

   always #2 clk = ~clk;

   sg_dma_engine #(.BURST_WORDS(BW)) u_sg_dma_engine (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .list_base_i(list_base_i),
      .status_clr_i(status_clr_i), .busy_o(busy_o), .irq_o(irq_o), .status_o(status_o),
      .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_valid_i(rd_valid_i),
      .rd_data_i(rd_data_i), .rd_err_i(rd_err_i), .wr_req_o(wr_req_o),
      .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o), .wr_ack_i(wr_ack_i), .wr_err_i(wr_err_i)
   );

   // Memory model: answers a held request one cycle later, one word per two cycles
   always @(negedge clk) begin
      if (rd_req_o && !rd_valid_i) begin
         rd_valid_i <= 1'b1;
         rd_data_i  <= mem[rd_addr_o[11:2]];
         rd_err_i   <= err_rd_en && (rd_addr_o == err_rd_addr);
      end else begin
         rd_valid_i <= 1'b0;
         rd_err_i   <= 1'b0;
      end
      if (wr_req_o && !wr_ack_i) begin
         wr_ack_i <= 1'b1;
         if (err_wr_en && (wr_addr_o == err_wr_addr)) begin
            wr_err_i <= 1'b1;
         end else begin
            wr_err_i <= 1'b0;
            mem[wr_addr_o[11:2]] <= wr_data_o;
         end
      end else begin
         wr_ack_i <= 1'b0;
         wr_err_i <= 1'b0;
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000) begin
         n_fail++;
         $display("FAIL watchdog: run did not end, actual=%0d expected=<150000 cycles", cyc);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic put_desc(input logic [31:0] a, input logic [31:0] s, input logic [31:0] d, input logic [31:0] c);
      mem[a[11:2]]     = s;
      mem[a[11:2] + 1] = d;
      mem[a[11:2] + 2] = c;
   endtask

   task automatic fill(input logic [31:0] a, input int words, input int seed);
      for (int i = 0; i < words; i++) mem[a[11:2] + i] = (32'h0403_0201 * (i + 1)) ^ (32'h5A00_0000 + seed);
   endtask

   task automatic wipe(input logic [31:0] a, input int words);
      for (int i = 0; i < words; i++) mem[a[11:2] + i] = '0;
   endtask

   // Counts words of dst that differ from src over n, plus nonzero words in the rest of span
   task automatic compare(input logic [31:0] s, input logic [31:0] d, input int n, input int span, output int bad);
      bad = 0;
      for (int i = 0; i < span; i++) begin
         if (i < n) begin
            if (mem[d[11:2] + i] !== mem[s[11:2] + i]) bad++;
         end else if (mem[d[11:2] + i] !== 32'h0) begin
            bad++;
         end
      end
   endtask

   task automatic pulse_start(input logic [31:0] b);
      @(negedge clk);
      list_base_i = b;
      start_i     = 1'b1;
      @(negedge clk);
      start_i     = 1'b0;
   endtask

   task automatic wait_idle(output bit early_irq);
      int lim = 0;
      early_irq = 1'b0;
      while (busy_o && lim < 5000) begin
         if (irq_o) early_irq = 1'b1;
         @(negedge clk);
         lim++;
      end
   endtask

   task automatic clear(input logic [4:0] m);
      @(negedge clk);
      status_clr_i = m;
      @(negedge clk);
      status_clr_i = '0;
   endtask

   initial begin
      int bad;
      bit early;
      for (int i = 0; i < 1024; i++) mem[i] = '0;
      repeat (3) @(negedge clk);
      check(!busy_o && !irq_o && status_o == 5'h0 && !rd_req_o && !wr_req_o,
            "R1 reset state", {busy_o, irq_o, rd_req_o, wr_req_o, status_o}, 32'h0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // Table walk: single descriptors, src 0x400, dst 0x800
      for (int k = 0; k < 6; k++) begin
         wipe(32'h800, 20);
         fill(32'h400, 20, k);
         put_desc(32'h0, 32'h400, 32'h800, T_CTRL[k]);
         pulse_start(32'h0);
         check(busy_o, "R9 start accepted", 32'(busy_o), 32'h1);
         wait_idle(early);
         check(status_o == T_ST[k], "R2 R6 table status", 32'(status_o), 32'(T_ST[k]));
         compare(32'h400, 32'h800, (T_ST[k] == 5'h03) ? int'(T_CTRL[k][17:0]) / 4 : 0, 20, bad);
         check(bad == 0, "R3 R6 table data", bad, 0);
         check(irq_o, "R11 irq set", 32'(irq_o), 32'h1);
         clear(5'h1F);
         check(status_o == 5'h0 && !irq_o, "R10 R11 clear all", {irq_o, status_o}, 32'h0);
      end

      // Three-descriptor list, last flag on the third
      wipe(32'h800, 48);
      fill(32'h400, 48, 9);
      put_desc(32'h00, 32'h400, 32'h800, 32'h0000_0010);
      put_desc(32'h0C, 32'h440, 32'h840, 32'h0000_0020);
      put_desc(32'h18, 32'h480, 32'h880, 32'h8000_0010);
      pulse_start(32'h0);
      wait_idle(early);
      check(!early, "R5 no irq before last done", 32'(early), 32'h0);
      check(status_o == 5'h03, "R5 list status", 32'(status_o), 32'h3);
      compare(32'h400, 32'h800, 4, 16, bad);
      check(bad == 0, "R4 first descriptor data", bad, 0);
      compare(32'h440, 32'h840, 8, 16, bad);
      check(bad == 0, "R4 second descriptor data", bad, 0);
      compare(32'h480, 32'h880, 4, 16, bad);
      check(bad == 0, "R4 third descriptor data", bad, 0);

      // Partial clears
      clear(5'h01);
      check(status_o == 5'h02 && irq_o, "R10 clear bit 0 only", {irq_o, status_o}, 32'h22);
      clear(5'h02);
      check(status_o == 5'h00 && !irq_o, "R11 irq drops", {irq_o, status_o}, 32'h0);

      // Second descriptor misaligned: first copied, second untouched
      wipe(32'h800, 32);
      fill(32'h400, 32, 3);
      put_desc(32'h00, 32'h400, 32'h800, 32'h0000_0010);
      put_desc(32'h0C, 32'h440, 32'h840, 32'h8000_0018);
      pulse_start(32'h0);
      wait_idle(early);
      check(status_o == 5'h10, "R6 bad second count", 32'(status_o), 32'h10);
      compare(32'h400, 32'h800, 4, 16, bad);
      check(bad == 0, "R4 data before bad descriptor", bad, 0);
      compare(32'h440, 32'h840, 0, 16, bad);
      check(bad == 0, "R6 no data for bad descriptor", bad, 0);
      clear(5'h1F);

      // Read error on data
      wipe(32'h800, 16);
      put_desc(32'h0, 32'h400, 32'h800, 32'h8000_0020);
      err_rd_en = 1'b1; err_rd_addr = 32'h408;
      pulse_start(32'h0);
      wait_idle(early);
      check(status_o == 5'h04 && !busy_o, "R7 data read error", {busy_o, status_o}, 32'h04);
      compare(32'h400, 32'h800, 0, 16, bad);
      check(bad == 0, "R7 nothing written", bad, 0);
      clear(5'h1F);

      // Read error on descriptor fetch
      err_rd_addr = 32'h4;
      pulse_start(32'h0);
      wait_idle(early);
      check(status_o == 5'h04, "R7 fetch read error", 32'(status_o), 32'h04);
      err_rd_en = 1'b0;
      clear(5'h1F);

      // Write error on second word
      wipe(32'h800, 16);
      fill(32'h400, 16, 5);
      err_wr_en = 1'b1; err_wr_addr = 32'h804;
      pulse_start(32'h0);
      wait_idle(early);
      check(status_o == 5'h08, "R8 write error", 32'(status_o), 32'h08);
      compare(32'h400, 32'h800, 1, 16, bad);
      check(bad == 0, "R8 writes stop at error", bad, 0);
      err_wr_en = 1'b0;
      clear(5'h1F);

      // Start while busy is ignored
      wipe(32'h800, 16);
      wipe(32'hC00, 8);
      fill(32'h400, 16, 7);
      put_desc(32'h000, 32'h400, 32'h800, 32'h8000_0030);
      put_desc(32'h100, 32'h400, 32'hC00, 32'h8000_0010);
      pulse_start(32'h0);
      repeat (3) @(negedge clk);
      pulse_start(32'h100);
      check(busy_o, "R9 still busy", 32'(busy_o), 32'h1);
      wait_idle(early);
      check(status_o == 5'h03, "R9 first list done", 32'(status_o), 32'h3);
      compare(32'h400, 32'h800, 12, 16, bad);
      check(bad == 0, "R9 first list data", bad, 0);
      compare(32'h400, 32'hC00, 0, 8, bad);
      check(bad == 0, "R9 ignored list untouched", bad, 0);
      repeat (4) @(negedge clk);
      check(!busy_o && !rd_req_o && !wr_req_o, "R12 quiet when idle",
            {busy_o, rd_req_o, wr_req_o}, 32'h0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule